// File: doc/BRIEF.md
# Line-Alternating Vertical Sequence Selector

This block produces the four vertical clock outputs of an image-sensor timing generator. A field starts at a field-sync pulse (`vd`) and ends at the next one. Each line starts at a line-sync pulse (`hd`). An internal line counter divides the field into five regions, using four programmable starting lines. For each output and region, two 4-bit selectors choose one of twelve stored waveforms: one selector for "first" lines and one for "second" lines. Each output also has one inversion bit for first lines and another for second lines.

Each stored waveform is a start level that flips at two programmable pixel positions. The pixel position is counted in clocks since the last line pulse. A region with alternation enabled starts on its first-line selection and then switches selection on every line. A region with alternation disabled uses the first-line settings throughout. All settings are captured at the field pulse, so a setting written mid-field first takes effect at the next field.

Top module: `vseq_alt_sel`

## Requirements
- R1: After reset, every bit of `vout` is 0, whatever the setting inputs hold, until a `vd` pulse captures new settings.
- R2: Waveform k has this level: `wave_init[k] ^ (pix >= wave_edge_a[k]) ^ (pix >= wave_edge_b[k])`. Here `pix` is 0 in the clock after a sampled `hd` or `vd` and rises by 1 per clock after that, saturating at its maximum.
- R3: The selector for output o and region r is the 4-bit field at bit `(o*5+r)*4` of `sel_first` / `sel_second`. Values 0 to 11 pick that waveform. Values 12 to 15 pick waveform 0.
- R4: Bit o of `inv_first` (or of `inv_second`) inverts output o whenever that output uses its first-line (or second-line) selection.
- R5: The line number is 0 after a `vd` pulse and rises by 1 on each `hd` pulse. The region is the highest k in 1..4 whose start line (field k-1 of `region_start`, 11 bits each) is at or below the line number. If no start line qualifies, the region is 0. A `vd` pulse in mid-field restarts at line 0.
- R6: In a region whose `alt_en` bit is 1, the region's first line uses the first-line settings. Each following line in that region uses the opposite settings to the line before it.
- R7: In a region whose `alt_en` bit is 0, every line uses the first-line settings. The second-line selectors and inversions have no effect on that region.
- R8: Changes to setting inputs take effect only at the next `vd` pulse. A line pulse alone leaves the settings in use unchanged.
- R9: When the line number crosses into a new region, that line uses the first-line settings, whatever the alternation state at the end of the previous region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| hd | input | 1 | Line pulse, one clock wide |
| vd | input | 1 | Field pulse, one clock wide; captures settings |
| wave_init | input | 12 | Start level per waveform |
| wave_edge_a | input | 132 | First toggle pixel per waveform, 11 bits each |
| wave_edge_b | input | 132 | Second toggle pixel per waveform, 11 bits each |
| region_start | input | 44 | Start lines of regions 1..4, 11 bits each |
| alt_en | input | 5 | Alternation enable per region |
| sel_first | input | 80 | First-line selectors, output-major, 4 bits each |
| sel_second | input | 80 | Second-line selectors, same layout |
| inv_first | input | 4 | First-line inversion per output |
| inv_second | input | 4 | Second-line inversion per output |
| vout | output | 4 | Vertical clock outputs |

## Verification
The assertions assume that `hd` and `vd` are single-clock pulses. They also assume the line counter never reaches its saturation value inside a field, since the line-step property excludes that case. The stimulus drives every pulse for exactly one clock and never raises `hd` and `vd` together. It also keeps fields to a handful of lines. Setting inputs change only between pulses, on the falling clock edge, so capture at `vd` is never ambiguous.

// File: rtl/vseq_alt_sel.sv
module vseq_alt_sel #(
  parameter int NOUT   = 4,
  parameter int NREG   = 5,
  parameter int NSEQ   = 12,
  parameter int PTR_W  = 4,
  parameter int LINE_W = 11,
  parameter int PIX_W  = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hd,
  input  logic                          vd,
  input  logic [NSEQ-1:0]               wave_init,
  input  logic [NSEQ*PIX_W-1:0]         wave_edge_a,
  input  logic [NSEQ*PIX_W-1:0]         wave_edge_b,
  input  logic [(NREG-1)*LINE_W-1:0]    region_start,
  input  logic [NREG-1:0]               alt_en,
  input  logic [NOUT*NREG*PTR_W-1:0]    sel_first,
  input  logic [NOUT*NREG*PTR_W-1:0]    sel_second,
  input  logic [NOUT-1:0]               inv_first,
  input  logic [NOUT-1:0]               inv_second,
  output logic [NOUT-1:0]               vout
);
  localparam int RG_W  = $clog2(NREG);
  localparam int SEL_W = NOUT*NREG*PTR_W;

  logic [NSEQ-1:0]            init_sh;
  logic [NSEQ*PIX_W-1:0]      edge_a_sh, edge_b_sh;
  logic [(NREG-1)*LINE_W-1:0] start_sh;
  logic [NREG-1:0]            alt_sh;
  logic [SEL_W-1:0]           sel_first_sh, sel_second_sh;
  logic [NOUT-1:0]            inv_first_sh, inv_second_sh;

  logic [LINE_W-1:0] line_q, line_nx;
  logic [PIX_W-1:0]  pix_q;
  logic              phase_q;
  logic [RG_W-1:0]   cur_rg, nxt_rg;
  logic [NSEQ-1:0]   wave;

  function automatic logic [RG_W-1:0] region_of(input logic [LINE_W-1:0] ln,
                                                input logic [(NREG-1)*LINE_W-1:0] b);
    region_of = '0;
    for (int k = 1; k < NREG; k++)
      if (b[(k-1)*LINE_W +: LINE_W] <= ln) region_of = RG_W'(k);
  endfunction

  assign line_nx = (line_q == '1) ? line_q : line_q + 1'b1;
  assign cur_rg  = region_of(line_q, start_sh);
  assign nxt_rg  = region_of(line_nx, start_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_sh       <= '0;
      edge_a_sh     <= '0;
      edge_b_sh     <= '0;
      start_sh      <= '0;
      alt_sh        <= '0;
      sel_first_sh  <= '0;
      sel_second_sh <= '0;
      inv_first_sh  <= '0;
      inv_second_sh <= '0;
      line_q        <= '0;
      pix_q         <= '0;
      phase_q       <= 1'b0;
    end else begin
      if (vd) begin
        init_sh       <= wave_init;
        edge_a_sh     <= wave_edge_a;
        edge_b_sh     <= wave_edge_b;
        start_sh      <= region_start;
        alt_sh        <= alt_en;
        sel_first_sh  <= sel_first;
        sel_second_sh <= sel_second;
        inv_first_sh  <= inv_first;
        inv_second_sh <= inv_second;
        line_q        <= '0;
        phase_q       <= 1'b0;
      end else if (hd) begin
        line_q  <= line_nx;
        phase_q <= (nxt_rg == cur_rg) && alt_sh[cur_rg] && !phase_q;
      end
      if (vd || hd)         pix_q <= '0;
      else if (pix_q != '1) pix_q <= pix_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NSEQ; k++) begin : g_wave
    assign wave[k] = init_sh[k]
                   ^ (pix_q >= edge_a_sh[k*PIX_W +: PIX_W])
                   ^ (pix_q >= edge_b_sh[k*PIX_W +: PIX_W]);
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic [PTR_W-1:0] ptr;
    assign ptr = phase_q ? sel_second_sh[(o*NREG + int'(cur_rg))*PTR_W +: PTR_W]
                         : sel_first_sh[(o*NREG + int'(cur_rg))*PTR_W +: PTR_W];
    assign vout[o] = ((ptr < PTR_W'(NSEQ)) ? wave[ptr] : wave[0])
                   ^ (phase_q ? inv_second_sh[o] : inv_first_sh[o]);
  end
endmodule

// File: rtl/vseq_alt_sel_chk.sv
module vseq_alt_sel_chk #(
  parameter int LINE_W = 11,
  parameter int PIX_W  = 11,
  parameter int SEL_W  = 80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hd,
  input logic              vd,
  input logic [LINE_W-1:0] line_q,
  input logic [PIX_W-1:0]  pix_q,
  input logic              phase_q,
  input logic [SEL_W-1:0]  sel_first_sh
);
  AST_PIX_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (hd || vd) |=> pix_q == '0); // R2
  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) vd |=> line_q == '0); // R5
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (hd && !vd && line_q != '1) |=> line_q == LINE_W'($past(line_q) + 1'b1)); // R5
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!hd && !vd) |=> $stable(line_q)); // R5
  AST_PHASE_FIELD: assert property (@(posedge clk) disable iff (!rst_n) vd |=> !phase_q); // R9
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!hd && !vd) |=> $stable(phase_q)); // R6
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !vd |=> $stable(sel_first_sh)); // R8
endmodule

bind vseq_alt_sel vseq_alt_sel_chk #(.LINE_W(LINE_W), .PIX_W(PIX_W), .SEL_W(NOUT*NREG*PTR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd), .line_q(line_q),
  .pix_q(pix_q), .phase_q(phase_q), .sel_first_sh(sel_first_sh)
);

// File: tb/test_vseq_alt_sel.sv
module test_vseq_alt_sel;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hd = 1'b0, vd = 1'b0;
  logic [11:0]  wave_init = '0;
  logic [131:0] wave_edge_a = '0, wave_edge_b = '0;
  logic [43:0]  region_start = '1;
  logic [4:0]   alt_en = '0;
  logic [79:0]  sel_first = '0, sel_second = '0;
  logic [3:0]   inv_first = '0, inv_second = '0;
  logic [3:0]   vout;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vseq_alt_sel i_vseq_alt_sel (
    .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd),
    .wave_init(wave_init), .wave_edge_a(wave_edge_a), .wave_edge_b(wave_edge_b),
    .region_start(region_start), .alt_en(alt_en),
    .sel_first(sel_first), .sel_second(sel_second),
    .inv_first(inv_first), .inv_second(inv_second), .vout(vout)
  );

  // {pointer, inversion, pixel, expected}; waveform k: init k%2, edges k+1 and 14
  localparam logic [9:0] VEC [12] = '{
    {4'd3,  1'b0, 4'd2,  1'b1}, {4'd3,  1'b0, 4'd5,  1'b0},
    {4'd3,  1'b1, 4'd5,  1'b1}, {4'd6,  1'b0, 4'd6,  1'b0},
    {4'd6,  1'b0, 4'd7,  1'b1}, {4'd11, 1'b0, 4'd11, 1'b1},
    {4'd11, 1'b0, 4'd12, 1'b0}, {4'd11, 1'b0, 4'd14, 1'b1},
    {4'd13, 1'b0, 4'd0,  1'b0}, {4'd13, 1'b0, 4'd1,  1'b1},
    {4'd15, 1'b1, 4'd3,  1'b0}, {4'd12, 1'b0, 4'd14, 1'b0}
  };

  task automatic check(input string req, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic pulse_vd();
    @(negedge clk) vd = 1'b1;
    @(negedge clk) vd = 1'b0;
  endtask

  task automatic pulse_hd();
    @(negedge clk) hd = 1'b1;
    @(negedge clk) hd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [0:8] pat;
    for (int k = 0; k < 12; k++) begin
      wave_init[k] = k[0];
      wave_edge_a[k*11 +: 11] = 11'(k + 1);
      wave_edge_b[k*11 +: 11] = 11'd14;
    end
    sel_first = {20{4'd7}};
    inv_first = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset vout0", vout[0], 1'b0);
    check("R1 reset vout3", vout[3], 1'b0);
    sel_first = '0;
    inv_first = '0;

    for (int i = 0; i < 12; i++) begin
      sel_first[3:0] = VEC[i][9:6];
      inv_first[0]   = VEC[i][5];
      pulse_vd();
      repeat (int'(VEC[i][4:1])) @(negedge clk);
      check($sformatf("R2/R3/R4 vector %0d", i), vout[0], VEC[i][0]);
    end

    sel_first[3:0] = 4'd3;
    pulse_hd();
    check("R8 held before vd", vout[0], 1'b0);
    pulse_vd();
    check("R8 taken at vd", vout[0], 1'b1);

    for (int o = 0; o < 4; o++)
      for (int r = 0; r < 5; r++) begin
        sel_first[(o*5+r)*4 +: 4]  = 4'd2;
        sel_second[(o*5+r)*4 +: 4] = 4'd5;
      end
    inv_first  = 4'b0010;
    inv_second = 4'b0010;
    region_start = {11'h7FF, 11'h7FF, 11'd6, 11'd3};
    alt_en = 5'b00110;
    pat = 9'b000_010_010;
    pulse_vd();
    for (int ln = 0; ln < 9; ln++) begin
      if (ln > 0) pulse_hd();
      check($sformatf("%s R5 line %0d", ln < 3 ? "R7" : (ln == 6 ? "R9" : "R6"), ln), vout[0], pat[ln]);
      check($sformatf("R4 inverted output line %0d", ln), vout[1], ~pat[ln]);
    end

    pulse_vd();
    check("R5 restart line 0", vout[0], 1'b0);
    repeat (4) pulse_hd();
    check("R5 line 4 after restart", vout[0], 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule